// File: doc/BRIEF.md
# DMA Channel Register Bank

This block is the software-visible register bank of one DMA channel. A register bus reads and writes sixteen word slots, with either a 16-bit or a 32-bit access width. The bank holds the descriptor pointer, the buffer start address, the channel configuration, the two-dimensional counts and strides, the working (current) pointer, address and counts, a status word and a peripheral routing word. Every stored value is presented as a plain output to the channel engine that sits beside it. Descriptor fetch, address stepping and data movement are the engine's job. The engine reports its progress back through a small update interface.

Software writes the configuration slot to start or stop the channel. A write with the enable bit set marks the channel as running. In the same cycle it copies the programmed pointer, address and counts into the working registers, and it raises one-cycle pulses toward the engine. A write with the enable bit clear stops the channel. While the channel runs, the bank refuses bus writes to the address, count, stride, working and routing slots. The status word has sticky completion and error flags that software clears by writing ones.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset every slot reads zero, except the routing slot (offset 0x2C), which reads the parameter PMAP_RESET (default 0x0040). All pulse outputs and running_o are low.
- R2: Slots are decoded from byte offset bits [5:2], in this order: 0x00 descriptor pointer, 0x04 start address, 0x08 configuration, 0x10 X count, 0x14 X stride, 0x18 Y count, 0x1C Y stride, 0x20 working descriptor pointer, 0x24 working address, 0x28 status, 0x2C routing, 0x30 working X count, 0x38 working Y count. Reads are combinational.
- R3: While the status run bit is set, bus writes to the pointer, address, count, stride, working and routing slots leave them unchanged. When the channel is not running, the same writes take effect.
- R4: A 32-bit write (bus_wide=1) replaces a 32-bit slot. A 16-bit write replaces only bits [15:0]. 16-bit slots keep the low 16 bits of either width. A 16-bit read returns bits [15:0] with the upper half zero.
- R5: A configuration write with bit 0 (enable) set does four things. It sets the run bit (status bit 3). It loads the working descriptor pointer and working address from the programmed pointer and start address. It loads the working X and Y counts from the programmed counts, with a count of zero loading 0xFFFF. It raises load_p for exactly the next cycle. The configuration slot accepts writes even while the channel runs.
- R6: A configuration write with bit 0 clear clears the run bit and raises stop_p for exactly the next cycle.
- R7: kick_p rises together with load_p only when routing bit 6 (channel type) is 0, or when configuration bit 1 (direction) of the written value is 1. Otherwise kick_p stays low.
- R8: Status bit 0 (done) and bit 1 (error) clear when the bus writes 1 to them. Status bit 3 (run) cannot be changed by a status write.
- R9: A routing write updates every bit except bit 6, which keeps its value.
- R10: A write to a reserved slot (0x0C, 0x34, 0x3C) or to a misaligned address changes no slot and raises bad_acc_p for exactly the next cycle. Reserved and misaligned reads return zero.
- R11: eng_upd loads all four working registers from the engine inputs, even while the channel runs. A setup load from a configuration write takes precedence over eng_upd in the same cycle. eng_err sets the error flag. eng_done sets the done flag and clears run unless a configuration write happens in the same cycle. An engine set of a flag takes precedence over a bus clear of that flag in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| bus_addr | input | AW | Byte offset within the bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| eng_upd | input | 1 | Engine loads the working registers |
| eng_desc | input | PTR_W | Engine working descriptor pointer |
| eng_addr | input | PTR_W | Engine working address |
| eng_xcnt | input | CNT_W | Engine working X count |
| eng_ycnt | input | CNT_W | Engine working Y count |
| eng_done | input | 1 | Engine reports completion |
| eng_err | input | 1 | Engine reports an error |
| cfg_o | output | 16 | Configuration value |
| next_desc_o | output | PTR_W | Programmed descriptor pointer |
| start_addr_o | output | PTR_W | Programmed start address |
| xcnt_o | output | CNT_W | Programmed X count |
| xmod_o | output | CNT_W | Programmed X stride |
| ycnt_o | output | CNT_W | Programmed Y count |
| ymod_o | output | CNT_W | Programmed Y stride |
| cur_desc_o | output | PTR_W | Working descriptor pointer |
| cur_addr_o | output | PTR_W | Working address |
| cur_x_o | output | CNT_W | Working X count |
| cur_y_o | output | CNT_W | Working Y count |
| pmap_o | output | 16 | Routing value |
| running_o | output | 1 | Status run bit |
| load_p | output | 1 | Setup-load pulse |
| kick_p | output | 1 | Engine self-start pulse |
| stop_p | output | 1 | Stop pulse |
| bad_acc_p | output | 1 | Reserved or misaligned write pulse |

## Verification
Writes are issued at both access widths to 32-bit and 16-bit slots. This separates full replacement from low-half merging, and shows whether a 16-bit read masks the upper half. The same slots are written once with the channel running and once with it stopped, so the lock is shown to depend on the run bit and not on the slot alone. Configuration writes are tried with a zero X count and a non-zero X count, with the direction bit set and clear, and with enable clear. These cases tell apart the 0xFFFF substitution, the kick condition and the stop path. Engine reports are made to coincide with bus status clears and with setup loads, which shows which side takes precedence.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;

  localparam int SLOT_N = 16;
  localparam int BUS_W  = 32;
  localparam int HALF_W = 16;

  // Slot index is byte offset [5:2]; the engine and software share this map.
  typedef enum logic [3:0] {
    SLOT_NDESC = 4'd0,
    SLOT_START = 4'd1,
    SLOT_CFG   = 4'd2,
    SLOT_RSV0  = 4'd3,
    SLOT_XCNT  = 4'd4,
    SLOT_XMOD  = 4'd5,
    SLOT_YCNT  = 4'd6,
    SLOT_YMOD  = 4'd7,
    SLOT_CDESC = 4'd8,
    SLOT_CADDR = 4'd9,
    SLOT_STAT  = 4'd10,
    SLOT_PMAP  = 4'd11,
    SLOT_CX    = 4'd12,
    SLOT_RSV1  = 4'd13,
    SLOT_CY    = 4'd14,
    SLOT_RSV2  = 4'd15
  } slot_e;

  localparam logic [SLOT_N-1:0] RSV_MASK = 16'hA008;

  localparam int CFG_EN_BIT    = 0;
  localparam int CFG_DIR_BIT   = 1;
  localparam int ST_DONE_BIT   = 0;
  localparam int ST_ERR_BIT    = 1;
  localparam int ST_RUN_BIT    = 3;
  localparam int PMAP_TYPE_BIT = 6;

endpackage

// File: rtl/dma_reg_decode.sv
module dma_reg_decode
  import dma_regs_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic [AW-1:0]     addr,
  input  logic              wr,
  output logic [3:0]        slot,
  output logic              hit,
  output logic [SLOT_N-1:0] wsel,
  output logic              bad_wr
);

  logic aligned;
  logic in_range;

  assign slot     = addr[5:2];
  assign aligned  = (addr[1:0] == 2'b00);
  assign in_range = ((addr >> 6) == '0);
  assign hit      = aligned && in_range && !RSV_MASK[slot];
  assign bad_wr   = wr && !hit;

  for (genvar i = 0; i < SLOT_N; i++) begin : g_sel
    assign wsel[i] = wr && hit && (slot == 4'(i));
  end

endmodule

// File: rtl/dma_reg_word.sv
module dma_reg_word #(
  parameter int           W   = 16,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_sel,
  input  logic         lock,
  input  logic         wide,
  input  logic [31:0]  wdata,
  input  logic         upd_en,
  input  logic [W-1:0] upd_val,
  output logic [W-1:0] q
);

  localparam int LO = (W < 16) ? W : 16;

  logic         en;
  logic [W-1:0] d;

  assign en = upd_en || (wr_sel && !lock);

  always_comb begin
    d = q;
    if (upd_en) begin
      d = upd_val;
    end else if (wr_sel && !lock) begin
      if (wide) d = wdata[W-1:0];
      else      d[LO-1:0] = wdata[LO-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST;
    else if (en) q <= d;
  end

  // R3: a bus write to a locked slot leaves it unchanged
  p_lock_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel && lock && !upd_en) |=> (q == $past(q)));

  // R11: an engine or setup load always lands
  p_upd_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> (q == $past(upd_val)));

endmodule

// File: rtl/dma_ctrl_status.sv
module dma_ctrl_status
  import dma_regs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic        st_wr,
  input  logic [15:0] wdata,
  input  logic        type_bit,
  input  logic        eng_done,
  input  logic        eng_err,
  output logic [15:0] cfg_q,
  output logic        run_q,
  output logic        done_q,
  output logic        err_q,
  output logic        load_now,
  output logic        load_p,
  output logic        kick_p,
  output logic        stop_p
);

  logic stop_now;
  logic kick_now;
  logic run_d;
  logic done_d;
  logic err_d;

  assign load_now = cfg_wr && wdata[CFG_EN_BIT];
  assign stop_now = cfg_wr && !wdata[CFG_EN_BIT];
  assign kick_now = load_now && (!type_bit || wdata[CFG_DIR_BIT]);

  always_comb begin
    if (cfg_wr)        run_d = wdata[CFG_EN_BIT];
    else if (eng_done) run_d = 1'b0;
    else               run_d = run_q;
    done_d = eng_done || (done_q && !(st_wr && wdata[ST_DONE_BIT]));
    err_d  = eng_err  || (err_q  && !(st_wr && wdata[ST_ERR_BIT]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_wr) cfg_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      load_p <= 1'b0;
      kick_p <= 1'b0;
      stop_p <= 1'b0;
    end else begin
      run_q  <= run_d;
      done_q <= done_d;
      err_q  <= err_d;
      load_p <= load_now;
      kick_p <= kick_now;
      stop_p <= stop_now;
    end
  end

  p_run_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && wdata[CFG_EN_BIT]) |=> (run_q && load_p));

  p_run_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !wdata[CFG_EN_BIT]) |=> (!run_q && stop_p));

  p_kick_needs_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    kick_p |-> load_p);

  p_w1c_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && wdata[ST_DONE_BIT] && !eng_done) |=> !done_q);

  p_run_not_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && !cfg_wr && !eng_done) |=> (run_q == $past(run_q)));

  p_eng_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && !cfg_wr) |=> (done_q && !run_q));

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regs_pkg::*;
#(
  parameter int          AW         = 6,
  parameter int          PTR_W      = 32,
  parameter int          CNT_W      = 16,
  parameter logic [15:0] PMAP_RESET = 16'h0040
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_wide,
  input  logic [AW-1:0]    bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic             eng_upd,
  input  logic [PTR_W-1:0] eng_desc,
  input  logic [PTR_W-1:0] eng_addr,
  input  logic [CNT_W-1:0] eng_xcnt,
  input  logic [CNT_W-1:0] eng_ycnt,
  input  logic             eng_done,
  input  logic             eng_err,
  output logic [15:0]      cfg_o,
  output logic [PTR_W-1:0] next_desc_o,
  output logic [PTR_W-1:0] start_addr_o,
  output logic [CNT_W-1:0] xcnt_o,
  output logic [CNT_W-1:0] xmod_o,
  output logic [CNT_W-1:0] ycnt_o,
  output logic [CNT_W-1:0] ymod_o,
  output logic [PTR_W-1:0] cur_desc_o,
  output logic [PTR_W-1:0] cur_addr_o,
  output logic [CNT_W-1:0] cur_x_o,
  output logic [CNT_W-1:0] cur_y_o,
  output logic [15:0]      pmap_o,
  output logic             running_o,
  output logic             load_p,
  output logic             kick_p,
  output logic             stop_p,
  output logic             bad_acc_p
);

  localparam int          N_CNT     = 4;
  localparam logic [31:0] TYPE_MASK = 32'(1) << PMAP_TYPE_BIT;

  logic [3:0]        slot;
  logic              hit;
  logic [SLOT_N-1:0] wsel;
  logic              bad_wr;
  logic              run_q;
  logic              done_q;
  logic              err_q;
  logic              load_now;
  logic              cur_upd;
  logic [15:0]       pmap_q;
  logic [31:0]       pmap_wdata;
  logic [CNT_W-1:0]  cnt_q [N_CNT];
  logic [CNT_W-1:0]  setup_x;
  logic [CNT_W-1:0]  setup_y;
  logic [15:0]       st_val;
  logic [31:0]       rd_raw;

  dma_reg_decode #(.AW(AW)) u_dec (
    .addr   (bus_addr),
    .wr     (bus_wr),
    .slot   (slot),
    .hit    (hit),
    .wsel   (wsel),
    .bad_wr (bad_wr)
  );

  dma_ctrl_status u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (wsel[SLOT_CFG]),
    .st_wr    (wsel[SLOT_STAT]),
    .wdata    (bus_wdata[15:0]),
    .type_bit (pmap_q[PMAP_TYPE_BIT]),
    .eng_done (eng_done),
    .eng_err  (eng_err),
    .cfg_q    (cfg_o),
    .run_q    (run_q),
    .done_q   (done_q),
    .err_q    (err_q),
    .load_now (load_now),
    .load_p   (load_p),
    .kick_p   (kick_p),
    .stop_p   (stop_p)
  );

  // Programmed pointer and address
  dma_reg_word #(.W(PTR_W)) u_ndesc (
    .clk(clk), .rst_n(rst_n), .wr_sel(wsel[SLOT_NDESC]), .lock(run_q),
    .wide(bus_wide), .wdata(bus_wdata), .upd_en(1'b0), .upd_val('0),
    .q(next_desc_o)
  );

  dma_reg_word #(.W(PTR_W)) u_start (
    .clk(clk), .rst_n(rst_n), .wr_sel(wsel[SLOT_START]), .lock(run_q),
    .wide(bus_wide), .wdata(bus_wdata), .upd_en(1'b0), .upd_val('0),
    .q(start_addr_o)
  );

  // Four programmed count/stride slots occupy consecutive slots from X count
  for (genvar k = 0; k < N_CNT; k++) begin : g_cnt
    dma_reg_word #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .wr_sel(wsel[int'(SLOT_XCNT) + k]),
      .lock(run_q), .wide(bus_wide), .wdata(bus_wdata),
      .upd_en(1'b0), .upd_val('0), .q(cnt_q[k])
    );
  end

  assign xcnt_o = cnt_q[0];
  assign xmod_o = cnt_q[1];
  assign ycnt_o = cnt_q[2];
  assign ymod_o = cnt_q[3];

  // Working registers: setup load beats engine update
  assign cur_upd = load_now || eng_upd;
  assign setup_x = (xcnt_o == '0) ? '1 : xcnt_o;
  assign setup_y = (ycnt_o == '0) ? '1 : ycnt_o;

  dma_reg_word #(.W(PTR_W)) u_cdesc (
    .clk(clk), .rst_n(rst_n), .wr_sel(wsel[SLOT_CDESC]), .lock(run_q),
    .wide(bus_wide), .wdata(bus_wdata), .upd_en(cur_upd),
    .upd_val(load_now ? next_desc_o : eng_desc), .q(cur_desc_o)
  );

  dma_reg_word #(.W(PTR_W)) u_caddr (
    .clk(clk), .rst_n(rst_n), .wr_sel(wsel[SLOT_CADDR]), .lock(run_q),
    .wide(bus_wide), .wdata(bus_wdata), .upd_en(cur_upd),
    .upd_val(load_now ? start_addr_o : eng_addr), .q(cur_addr_o)
  );

  dma_reg_word #(.W(CNT_W)) u_cx (
    .clk(clk), .rst_n(rst_n), .wr_sel(wsel[SLOT_CX]), .lock(run_q),
    .wide(bus_wide), .wdata(bus_wdata), .upd_en(cur_upd),
    .upd_val(load_now ? setup_x : eng_xcnt), .q(cur_x_o)
  );

  dma_reg_word #(.W(CNT_W)) u_cy (
    .clk(clk), .rst_n(rst_n), .wr_sel(wsel[SLOT_CY]), .lock(run_q),
    .wide(bus_wide), .wdata(bus_wdata), .upd_en(cur_upd),
    .upd_val(load_now ? setup_y : eng_ycnt), .q(cur_y_o)
  );

  // Routing: channel-type bit is fed back so a write cannot alter it
  assign pmap_wdata = (bus_wdata & ~TYPE_MASK) | ({16'b0, pmap_q} & TYPE_MASK);

  dma_reg_word #(.W(16), .RST(PMAP_RESET)) u_pmap (
    .clk(clk), .rst_n(rst_n), .wr_sel(wsel[SLOT_PMAP]), .lock(run_q),
    .wide(bus_wide), .wdata(pmap_wdata), .upd_en(1'b0), .upd_val('0),
    .q(pmap_q)
  );

  assign pmap_o    = pmap_q;
  assign running_o = run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bad_acc_p <= 1'b0;
    else        bad_acc_p <= bad_wr;
  end

  // Read-back
  always_comb begin
    st_val              = '0;
    st_val[ST_DONE_BIT] = done_q;
    st_val[ST_ERR_BIT]  = err_q;
    st_val[ST_RUN_BIT]  = run_q;
    rd_raw = '0;
    if (hit) begin
      case (slot)
        SLOT_NDESC: rd_raw = 32'(next_desc_o);
        SLOT_START: rd_raw = 32'(start_addr_o);
        SLOT_CFG:   rd_raw = 32'(cfg_o);
        SLOT_XCNT:  rd_raw = 32'(xcnt_o);
        SLOT_XMOD:  rd_raw = 32'(xmod_o);
        SLOT_YCNT:  rd_raw = 32'(ycnt_o);
        SLOT_YMOD:  rd_raw = 32'(ymod_o);
        SLOT_CDESC: rd_raw = 32'(cur_desc_o);
        SLOT_CADDR: rd_raw = 32'(cur_addr_o);
        SLOT_STAT:  rd_raw = 32'(st_val);
        SLOT_PMAP:  rd_raw = 32'(pmap_q);
        SLOT_CX:    rd_raw = 32'(cur_x_o);
        SLOT_CY:    rd_raw = 32'(cur_y_o);
        default:    rd_raw = '0;
      endcase
    end
  end

  assign bus_rdata = bus_wide ? rd_raw : {16'b0, rd_raw[15:0]};

  p_bad_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bad_wr |=> bad_acc_p);

  p_type_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pmap_q[PMAP_TYPE_BIT] == $past(pmap_q[PMAP_TYPE_BIT])));

  p_pulse_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_p, stop_p}));

endmodule

// File: tb/dma_chan_regs_bench.sv
`timescale 1ns/100ps
module dma_chan_regs_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_wide = 1'b1;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        eng_upd = 1'b0;
  logic [31:0] eng_desc = '0;
  logic [31:0] eng_addr = '0;
  logic [15:0] eng_xcnt = '0;
  logic [15:0] eng_ycnt = '0;
  logic        eng_done = 1'b0;
  logic        eng_err = 1'b0;
  logic [15:0] cfg_o, xcnt_o, xmod_o, ycnt_o, ymod_o, cur_x_o, cur_y_o, pmap_o;
  logic [31:0] next_desc_o, start_addr_o, cur_desc_o, cur_addr_o;
  logic        running_o, load_p, kick_p, stop_p, bad_acc_p;

  int n_chk = 0;
  int n_fail = 0;
  bit fin = 1'b0;

  always #2.5 clk = ~clk;

  dma_chan_regs u_dma_chan_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wide(bus_wide),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_upd(eng_upd), .eng_desc(eng_desc), .eng_addr(eng_addr),
    .eng_xcnt(eng_xcnt), .eng_ycnt(eng_ycnt), .eng_done(eng_done),
    .eng_err(eng_err), .cfg_o(cfg_o), .next_desc_o(next_desc_o),
    .start_addr_o(start_addr_o), .xcnt_o(xcnt_o), .xmod_o(xmod_o),
    .ycnt_o(ycnt_o), .ymod_o(ymod_o), .cur_desc_o(cur_desc_o),
    .cur_addr_o(cur_addr_o), .cur_x_o(cur_x_o), .cur_y_o(cur_y_o),
    .pmap_o(pmap_o), .running_o(running_o), .load_p(load_p),
    .kick_p(kick_p), .stop_p(stop_p), .bad_acc_p(bad_acc_p)
  );

  // ---------------- reference model ----------------
  logic [31:0] m [16];
  bit m_run, m_done, m_err, m_load, m_kick, m_stop, m_bad;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] model_rd(input logic [5:0] a, input logic w);
    logic [31:0] v;
    int o;
    o = int'(a[5:2]);
    if (a[1:0] != 2'b00 || o == 3 || o == 13 || o == 15) v = 32'h0;
    else if (o == 10) v = {28'h0, m_run, 1'b0, m_err, m_done};
    else v = m[o];
    return w ? v : {16'h0, v[15:0]};
  endfunction

  task automatic model_step();
    int o;
    bit rsv, old_run, cfgw;
    o = int'(bus_addr[5:2]);
    rsv = (bus_addr[1:0] != 2'b00) || o == 3 || o == 13 || o == 15;
    old_run = m_run;
    cfgw = bus_wr && !rsv && o == 2;
    m_load = 0; m_kick = 0; m_stop = 0; m_bad = 0;
    if (bus_wr) begin
      if (rsv) m_bad = 1;
      else if (o == 2) begin
        m[2] = bus_wdata & 32'hFFFF;
        if (bus_wdata[0]) begin
          m_load = 1;
          m_kick = !m[11][6] || bus_wdata[1];
          m_run = 1;
        end else begin
          m_stop = 1;
          m_run = 0;
        end
      end else if (o == 10) begin
        if (bus_wdata[0]) m_done = 0;
        if (bus_wdata[1]) m_err = 0;
      end else if (!old_run) begin
        if (o == 11) m[11] = ((bus_wdata & 32'hFFFF) & ~32'h40) | (m[11] & 32'h40);
        else if (o == 0 || o == 1 || o == 8 || o == 9)
          m[o] = bus_wide ? bus_wdata : {m[o][31:16], bus_wdata[15:0]};
        else m[o] = bus_wdata & 32'hFFFF;
      end
    end
    if (eng_upd) begin
      m[8] = eng_desc; m[9] = eng_addr;
      m[12] = {16'h0, eng_xcnt}; m[14] = {16'h0, eng_ycnt};
    end
    if (eng_done) begin
      m_done = 1;
      if (!cfgw) m_run = 0;
    end
    if (eng_err) m_err = 1;
    if (m_load) begin
      m[8] = m[0]; m[9] = m[1];
      m[12] = (m[4] == 0) ? 32'hFFFF : m[4];
      m[14] = (m[6] == 0) ? 32'hFFFF : m[6];
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) m[i] = 32'h0;
      m[11] = 32'h40;
      m_run = 0; m_done = 0; m_err = 0;
      m_load = 0; m_kick = 0; m_stop = 0; m_bad = 0;
    end else begin
      model_step();
    end
  end

  // Cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !fin) begin
      chk("R2 cycle rdata", bus_rdata, model_rd(bus_addr, bus_wide));
      chk("R5 cycle run", {31'h0, running_o}, {31'h0, m_run});
      chk("R5 cycle load_p", {31'h0, load_p}, {31'h0, m_load});
      chk("R7 cycle kick_p", {31'h0, kick_p}, {31'h0, m_kick});
      chk("R6 cycle stop_p", {31'h0, stop_p}, {31'h0, m_stop});
      chk("R10 cycle bad_acc_p", {31'h0, bad_acc_p}, {31'h0, m_bad});
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [5:0] a, input logic w, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1; bus_addr = a; bus_wide = w; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, input logic w, input logic [31:0] e, input string tag);
    bus_addr = a; bus_wide = w;
    #1;
    chk(tag, bus_rdata, e);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    rd(6'h2C, 1, 32'h40, "R1 pmap reset");
    rd(6'h08, 1, 32'h0, "R1 cfg reset");
    rd(6'h28, 1, 32'h0, "R1 status reset");
    rd(6'h30, 1, 32'h0, "R1 cur_x reset");
    chk("R1 pulses reset", {28'h0, load_p, kick_p, stop_p, bad_acc_p}, 32'h0);
    // R2 / R4 widths
    wr(6'h00, 1, 32'h12345678);
    rd(6'h00, 1, 32'h12345678, "R2 descriptor slot");
    wr(6'h00, 0, 32'h9999BEEF);
    rd(6'h00, 1, 32'h1234BEEF, "R4 narrow merge");
    rd(6'h00, 0, 32'h0000BEEF, "R4 narrow read");
    wr(6'h04, 1, 32'h00001000);
    wr(6'h10, 1, 32'hABCD0000);
    rd(6'h10, 1, 32'h0, "R4 16-bit slot wide write");
    wr(6'h14, 1, 32'h4);
    wr(6'h18, 1, 32'h2);
    wr(6'h1C, 1, 32'h8);
    rd(6'h1C, 1, 32'h8, "R2 Y stride slot");
    // R5 start with zero X count, type=1 dir=0 -> no kick
    wr(6'h08, 0, 32'h0001);
    chk("R5 load_p", {31'h0, load_p}, 32'h1);
    chk("R7 no kick", {31'h0, kick_p}, 32'h0);
    rd(6'h30, 1, 32'hFFFF, "R5 zero count becomes 0xFFFF");
    rd(6'h38, 1, 32'h2, "R5 Y count load");
    rd(6'h24, 1, 32'h1000, "R5 address load");
    rd(6'h20, 1, 32'h1234BEEF, "R5 descriptor load");
    rd(6'h28, 1, 32'h8, "R5 run bit");
    // R3 locks
    wr(6'h04, 1, 32'h2222);
    rd(6'h04, 1, 32'h1000, "R3 start locked");
    wr(6'h2C, 1, 32'h0);
    rd(6'h2C, 1, 32'h40, "R3 routing locked");
    wr(6'h30, 1, 32'h7);
    rd(6'h30, 1, 32'hFFFF, "R3 working count locked");
    // R8 run not writable
    wr(6'h28, 1, 32'hFFFF);
    rd(6'h28, 1, 32'h8, "R8 run kept");
    // R11 engine
    @(posedge clk); #1;
    eng_upd = 1; eng_desc = 32'hCAFE0000; eng_addr = 32'h1004;
    eng_xcnt = 16'hFFFE; eng_ycnt = 16'h2;
    @(posedge clk); #1;
    eng_upd = 0;
    rd(6'h24, 1, 32'h1004, "R11 engine address");
    rd(6'h30, 1, 32'hFFFE, "R11 engine X count");
    rd(6'h20, 1, 32'hCAFE0000, "R11 engine descriptor");
    eng_err = 1;
    @(posedge clk); #1;
    eng_err = 0;
    rd(6'h28, 1, 32'hA, "R11 error flag");
    bus_wr = 1; bus_addr = 6'h28; bus_wide = 1; bus_wdata = 32'h1; eng_done = 1;
    @(posedge clk); #1;
    bus_wr = 0; eng_done = 0;
    rd(6'h28, 1, 32'h3, "R11 engine set beats clear");
    chk("R11 done clears run", {31'h0, running_o}, 32'h0);
    wr(6'h28, 1, 32'h3);
    rd(6'h28, 1, 32'h0, "R8 w1c");
    // R7 kick via direction, R6 stop
    wr(6'h08, 1, 32'h0003);
    chk("R7 kick with direction", {31'h0, kick_p}, 32'h1);
    rd(6'h30, 1, 32'hFFFF, "R5 reload");
    wr(6'h08, 1, 32'h0000);
    chk("R6 stop_p", {31'h0, stop_p}, 32'h1);
    rd(6'h28, 1, 32'h0, "R6 run cleared");
    // R9 routing
    wr(6'h2C, 1, 32'h0005);
    rd(6'h2C, 1, 32'h45, "R9 type kept");
    wr(6'h2C, 0, 32'hFFBF);
    rd(6'h2C, 1, 32'hFFFF, "R9 other bits");
    // R5 non-zero count
    wr(6'h10, 1, 32'h5);
    wr(6'h08, 1, 32'h1);
    rd(6'h30, 1, 32'h5, "R5 count load");
    wr(6'h08, 1, 32'h0);
    // R10 reserved / misaligned
    wr(6'h0C, 1, 32'hFFFFFFFF);
    chk("R10 reserved pulse", {31'h0, bad_acc_p}, 32'h1);
    rd(6'h0C, 1, 32'h0, "R10 reserved read");
    wr(6'h02, 1, 32'h55);
    chk("R10 misaligned pulse", {31'h0, bad_acc_p}, 32'h1);
    rd(6'h00, 1, 32'h1234BEEF, "R10 misaligned ignored");
    // R3 unlocked write
    wr(6'h30, 1, 32'h7);
    chk("R10 no pulse on good write", {31'h0, bad_acc_p}, 32'h0);
    rd(6'h30, 1, 32'h7, "R3 unlocked write");
    rd(6'h08, 1, 32'h0, "R2 cfg readback");
    repeat (2) @(posedge clk);
    fin = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      fin = 1;
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

endmodule